// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer and Refresh Scheduler

This block owns the SDRAM clock-enable pin and the refresh-related commands. On a sleep request it puts the device into self refresh by issuing the self-refresh command with clock enable low, then holds clock enable low. When a wake request arrives, it does not raise clock enable at once. It first waits until the clock-stable input is seen high while clock enable is still low. It then raises clock enable and drives a window of NOP commands, so that any refresh the device started internally can finish. This window lasts the exit recovery time converted to clocks, and never less than two clocks.

When the window closes, the block reports the device usable and restarts its refresh timer in the same step. In normal operation it issues AUTO REFRESH at a fixed period that never exceeds the required interval. It also raises a one-cycle warning flag ahead of each refresh, so the main controller can keep the command bus free. Both time limits are parameters in nanoseconds. The exit time is rounded up to whole clocks. The refresh period is rounded down, so the refresh is never late.

Top module: `sdr_sleep_sched`

## Requirements
- R1: During and right after reset, cke_o is 1, cmd_o is NOP (2'b00), ready_o is 1 and refresh_due_o is 0.
- R2: A sleep_req_i sampled high in normal operation gives, in the next cycle, cmd_o = SELF REFRESH (2'b10) with cke_o = 0. The cycles after that show cmd_o = NOP with cke_o still 0.
- R3: After a wake request, cke_o stays 0 for at least one cycle. It stays 0 for as long as clk_stable_i is sampled low. It rises only in the cycle after clk_stable_i was sampled high.
- R4: From the cycle in which cke_o rises, exactly max(2, ceil(TXSR_NS*1000/CLK_PS)) cycles show cmd_o = NOP with ready_o = 0. In the bench this is 7 cycles for TXSR_NS=70 and 2 cycles for TXSR_NS=5, with CLK_PS=10000.
- R5: ready_o is 0 from the self-refresh command cycle through the last NOP window cycle, and 1 in normal operation.
- R6: The refresh timer restarts when the NOP window ends. The first AUTO REFRESH (2'b01) appears REF_CYC-1 cycles after the first cycle with ready_o high.
- R7: refresh_due_o is high for exactly the one cycle before each AUTO REFRESH cycle.
- R8: In normal operation, consecutive AUTO REFRESH commands are exactly REF_CYC = floor(TREFI_NS*1000/CLK_PS) cycles apart (40 in the bench).
- R9: A sleep request sampled in the cycle where refresh_due_o is high wins over the refresh. The next cycle carries SELF REFRESH and no AUTO REFRESH is issued.
- R10: A wake request in normal operation has no effect, and a sleep request while in self refresh has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_stable_i | input | 1 | Device clock is running within its limits |
| sleep_req_i | input | 1 | Request to enter self refresh |
| wake_req_i | input | 1 | Request to leave self refresh |
| cke_o | output | 1 | SDRAM clock enable |
| cmd_o | output | 2 | Command: 0 NOP, 1 AUTO REFRESH, 2 SELF REFRESH |
| refresh_due_o | output | 1 | Refresh is issued next cycle; main controller holds off |
| ready_o | output | 1 | Device usable by the main controller |

## Verification
The hardest situation to reach is a sleep request that lands in the same cycle as the refresh warning. That cycle comes only once per refresh period and depends on when the timer was last restarted. The bench watches refresh_due_o at the ports and raises sleep_req_i in the cycle it sees the flag. It then checks that self refresh is entered without an AUTO REFRESH. A wake request held while the clock is reported unstable is also driven for several cycles, to show that clock enable stays low until stability is seen.

// File: rtl/sdr_sleep_pkg.sv
package sdr_sleep_pkg;

   typedef enum logic [1:0] {
      CMD_NOP  = 2'd0,
      CMD_AREF = 2'd1,
      CMD_SREF = 2'd2
   } sdr_cmd_e;

   typedef enum logic [2:0] {
      ST_RUN,
      ST_SR_ENTER,
      ST_ASLEEP,
      ST_WAIT_CLK,
      ST_EXIT_NOP
   } slp_state_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/sdr_exit_win.sv
module sdr_exit_win #(
   parameter int NOP_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic active_i,
   output logic done_o
);
   localparam int W = $clog2(NOP_CYC + 1);

   if (NOP_CYC < 2) begin : g_bad
      $error("sdr_exit_win: NOP_CYC must be at least 2");
   end

   if (NOP_CYC == 2) begin : g_two
      logic second;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         second <= 1'b0;
         else if (start_i)   second <= 1'b0;
         else if (active_i)  second <= 1'b1;
      end
      assign done_o = active_i && second;
   end else begin : g_cnt
      logic [W-1:0] left;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         left <= '0;
         else if (start_i)                   left <= W'(NOP_CYC - 1);
         else if (active_i && left != '0)    left <= left - 1'b1;
      end
      assign done_o = active_i && (left == '0);
   end

   // window length observer
   logic [W-1:0] run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        run_len <= '0;
      else if (!active_i)                run_len <= '0;
      else if (run_len != '1)            run_len <= run_len + 1'b1;
   end

   assert_win_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (run_len == W'(NOP_CYC - 1)));

endmodule

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
   parameter int REF_CYC = 1953
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reload_i,
   input  logic run_i,
   output logic expire_o
);
   localparam int CW = $clog2(REF_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(REF_CYC - 2);

   if (REF_CYC < 4) begin : g_bad
      $error("sdr_ref_timer: REF_CYC must be at least 4");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= LOAD;
      else if (reload_i)             cnt <= LOAD;
      else if (run_i && cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expire_o = run_i && (cnt == CW'(1));

endmodule

// File: rtl/sdr_sleep_sched.sv
module sdr_sleep_sched
   import sdr_sleep_pkg::*;
#(
   parameter int CLK_PS   = 8000,
   parameter int TXSR_NS  = 70,
   parameter int TREFI_NS = 15625
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clk_stable_i,
   input  logic       sleep_req_i,
   input  logic       wake_req_i,
   output logic       cke_o,
   output logic [1:0] cmd_o,
   output logic       refresh_due_o,
   output logic       ready_o
);
   localparam int TXSR_CYC = ceil_div(TXSR_NS * 1000, CLK_PS);
   localparam int NOP_CYC  = (TXSR_CYC < 2) ? 2 : TXSR_CYC;
   localparam int REF_CYC  = (TREFI_NS * 1000) / CLK_PS;
   localparam int CW       = $clog2(REF_CYC + 1);

   if (CLK_PS <= 0) begin : g_bad_clk
      $error("sdr_sleep_sched: CLK_PS must be positive");
   end

   slp_state_e state, state_nxt;
   logic       due_q, aref_q;
   logic       win_start, win_active, win_done;
   logic       tmr_expire, tmr_reload, in_run;
   sdr_cmd_e   cmd_e;

   assign in_run     = (state == ST_RUN);
   assign win_start  = (state == ST_WAIT_CLK) && clk_stable_i;
   assign win_active = (state == ST_EXIT_NOP);
   assign tmr_reload = aref_q || win_done;

   always_comb begin
      state_nxt = state;
      unique case (state)
         ST_RUN:      if (sleep_req_i)  state_nxt = ST_SR_ENTER;
         ST_SR_ENTER:                   state_nxt = ST_ASLEEP;
         ST_ASLEEP:   if (wake_req_i)   state_nxt = ST_WAIT_CLK;
         ST_WAIT_CLK: if (clk_stable_i) state_nxt = ST_EXIT_NOP;
         ST_EXIT_NOP: if (win_done)     state_nxt = ST_RUN;
         default:                       state_nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_RUN;
         due_q  <= 1'b0;
         aref_q <= 1'b0;
      end else begin
         state  <= state_nxt;
         due_q  <= in_run && !sleep_req_i && tmr_expire && !due_q && !aref_q;
         aref_q <= in_run && !sleep_req_i && due_q;
      end
   end

   sdr_exit_win #(.NOP_CYC(NOP_CYC)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (win_start),
      .active_i (win_active),
      .done_o   (win_done)
   );

   sdr_ref_timer #(.REF_CYC(REF_CYC)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .reload_i (tmr_reload),
      .run_i    (in_run),
      .expire_o (tmr_expire)
   );

   always_comb begin
      cmd_e = CMD_NOP;
      if (state == ST_SR_ENTER)  cmd_e = CMD_SREF;
      else if (in_run && aref_q) cmd_e = CMD_AREF;
   end

   assign cmd_o         = cmd_e;
   assign cke_o         = !((state == ST_SR_ENTER) || (state == ST_ASLEEP) ||
                            (state == ST_WAIT_CLK));
   assign ready_o       = in_run;
   assign refresh_due_o = due_q;

   // cycles since last refresh or since becoming usable
   logic [CW:0] gap;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               gap <= '0;
      else if (!ready_o || cmd_o == CMD_AREF)   gap <= '0;
      else if (gap != '1)                       gap <= gap + 1'b1;
   end

   assert_cke_after_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke_o) |-> $past(clk_stable_i));

   assert_window_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cke_o && !ready_o) |-> (cmd_o == CMD_NOP));

   assert_ready_cke_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> cke_o);

   assert_due_then_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_due_o |=> (cmd_o == CMD_AREF || cmd_o == CMD_SREF));

   assert_aref_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gap < (CW+1)'(REF_CYC));

   assert_sref_cke_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_SREF) |-> !cke_o);

endmodule

// File: tb/sdr_sleep_sched_bench.sv
`timescale 1ns/1ps
module sdr_sleep_sched_bench;

   localparam int CLK_PS = 10000;
   localparam int REF    = 40;
   localparam int NOPW   = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stable = 1'b0, sleep = 1'b0, wake = 1'b0;
   logic       cke, due, rdy, cke_m, due_m, rdy_m;
   logic [1:0] cmd, cmd_m;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sdr_sleep_sched #(.CLK_PS(CLK_PS), .TXSR_NS(70), .TREFI_NS(400)) u_sdr_sleep_sched (
      .clk(clk), .rst_n(rst_n), .clk_stable_i(stable), .sleep_req_i(sleep),
      .wake_req_i(wake), .cke_o(cke), .cmd_o(cmd), .refresh_due_o(due), .ready_o(rdy));

   sdr_sleep_sched #(.CLK_PS(CLK_PS), .TXSR_NS(5), .TREFI_NS(400)) u_sdr_sleep_sched_min (
      .clk(clk), .rst_n(rst_n), .clk_stable_i(stable), .sleep_req_i(sleep),
      .wake_req_i(wake), .cke_o(cke_m), .cmd_o(cmd_m), .refresh_due_o(due_m), .ready_o(rdy_m));

   // {sleep, wake, stable, exp_cke, exp_cmd[1:0], exp_ready, exp_ready_min}
   localparam logic [7:0] TBL [14] = '{
      8'b000_1_00_1_1,  // run idle
      8'b100_0_10_0_0,  // sleep -> SREF
      8'b000_0_00_0_0,  // asleep
      8'b010_0_00_0_0,  // wake, clock unstable
      8'b000_0_00_0_0,
      8'b000_0_00_0_0,
      8'b001_1_00_0_0,  // stable -> cke high, window 1
      8'b001_1_00_0_0,
      8'b001_1_00_0_1,  // short window done
      8'b001_1_00_0_1,
      8'b001_1_00_0_1,
      8'b001_1_00_0_1,
      8'b001_1_00_0_1,  // window cycle 7
      8'b001_1_00_1_1   // ready
   };

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      int k0, due1, due2, ar1, ar2, nw;
      repeat (3) step();
      chk("R1 cke in reset", int'(cke), 1);
      chk("R1 ready in reset", int'(rdy), 1);
      rst_n = 1'b1;
      step();
      chk("R1 cmd after reset", int'(cmd), 0);
      chk("R1 due after reset", int'(due), 0);

      // table walk: R2 R3 R4 R5
      for (int i = 0; i < 14; i++) begin
         sleep  = TBL[i][7];
         wake   = TBL[i][6];
         stable = TBL[i][5];
         step();
         chk($sformatf("R2/R3 cke row %0d", i), int'(cke), int'(TBL[i][4]));
         chk($sformatf("R2 cmd row %0d", i), int'(cmd), int'(TBL[i][3:2]));
         chk($sformatf("R4/R5 ready row %0d", i), int'(rdy), int'(TBL[i][1]));
         chk($sformatf("R4 short ready row %0d", i), int'(rdy_m), int'(TBL[i][0]));
         chk($sformatf("R3 short cke row %0d", i), int'(cke_m), int'(TBL[i][4]));
      end

      // R6 R7 R8: timer restart and period
      due1 = -1; due2 = -1; ar1 = -1; ar2 = -1;
      for (int k = 1; k <= 85; k++) begin
         step();
         if (due) begin
            if (due1 < 0) due1 = k; else if (due2 < 0) due2 = k;
         end
         if (cmd == 2'd1) begin
            if (ar1 < 0) ar1 = k; else if (ar2 < 0) ar2 = k;
         end
      end
      chk("R6 first refresh after ready", ar1, REF - 1);
      chk("R7 first due precedes refresh", due1, ar1 - 1);
      chk("R8 refresh spacing", ar2 - ar1, REF);
      chk("R7 second due precedes refresh", due2, ar2 - 1);

      // R10: wake in normal operation ignored
      wake = 1'b1;
      step();
      wake = 1'b0;
      step();
      chk("R10 wake ignored ready", int'(rdy), 1);
      chk("R10 wake ignored cke", int'(cke), 1);

      // R9: sleep on the due cycle
      k0 = 0;
      while (!due && k0 < 60) begin
         step();
         k0++;
      end
      chk("R9 due seen", int'(due), 1);
      sleep = 1'b1;
      step();
      chk("R9 sleep beats refresh cmd", int'(cmd), 2);
      chk("R9 cke low", int'(cke), 0);

      // R10: sleep held while asleep ignored
      for (int j = 0; j < 5; j++) begin
         step();
         chk("R10 sleep ignored cmd", int'(cmd), 0);
         chk("R10 sleep ignored cke", int'(cke), 0);
      end
      sleep = 1'b0;

      // R3: clock already stable, still one low cycle after wake
      wake = 1'b1;
      stable = 1'b1;
      step();
      wake = 1'b0;
      chk("R3 cke low after wake", int'(cke), 0);
      step();
      chk("R3 cke rises", int'(cke), 1);
      nw = 1;
      for (int j = 0; j < 20 && !rdy; j++) begin
         step();
         if (!rdy) nw++;
      end
      chk("R4 window length second exit", nw, NOPW);
      chk("R5 ready after window", int'(rdy), 1);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule